// File: doc/BRIEF.md
# Multi-Length AES Round-Key Generator

This block produces AES encryption round keys on the fly for 128, 192 and 256-bit cipher keys. It feeds an iterative cipher datapath that consumes one 128-bit round key per clock. A start strobe, qualified by a non-zero mode, loads the cipher key, which is left-aligned on a 256-bit bus. The whitening key (round 0) appears on the next clock. After that, each clock presents the following round key together with its round index, until the final round of the selected key length has been reached.

A single engine serves all three key lengths. An eight-word sliding window holds the most recent expanded words. Four chained word lanes compute the next four words in one cycle, so one full round key comes out every cycle. This holds even for 192-bit keys, where the six-word expansion period does not line up with the four-word round-key boundary. Mode 0 is a hold state: the window, the round constant, the phase and the round index all keep their values until a non-zero mode returns.

Top module: `aes_key_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `rnd` = 0 and `rkey` = 0.
- R2: A clock edge with `start` = 1 and `mode` != 0 makes the next outputs `rnd` = 0 and `rkey` = `key_in[255:128]`. This is round key 0.
- R3: After a load, each edge with `mode` != 0 and `start` = 0 raises `rnd` by one and presents the next four expanded words, with word 4·rnd in bits 127:96. This continues until the last round index is reached.
- R4: Mode 1 (Nk = 4) yields the eleven standard round keys 0..10. Every fourth word applies RotWord, SubWord and the round constant, which starts at 0x01 and doubles modulo 0x11B.
- R5: Mode 2 (Nk = 6) yields the thirteen standard round keys 0..12. The recurrence runs on a six-word period, independent of the round-key boundary.
- R6: Mode 3 (Nk = 8) yields the fifteen standard round keys 0..14. This includes the extra SubWord applied without rotation or constant when i mod 8 = 4.
- R7: Once `rnd` equals the last index (10, 12 or 14), `rnd` and `rkey` hold until the next load.
- R8: Any edge with `mode` = 0 leaves `rnd`, `rkey` and all internal schedule state unchanged. Generation resumes where it stopped once a non-zero mode returns.
- R9: `start` = 1 with `mode` = 0 is ignored; the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | 0 hold, 1 128-bit key, 2 192-bit key, 3 256-bit key |
| start | input | 1 | Load strobe for a new cipher key |
| key_in | input | 256 | Cipher key, left-aligned (a 128-bit key sits in bits 255:128) |
| rkey | output | 128 | Current round key, lowest-numbered word in bits 127:96 |
| rnd | output | 4 | Index of the round key on `rkey` |

## Verification
The bench builds the block with its package defaults: 32-bit words, four words per round key and an eight-word window. With these values all three key lengths can be reached on one instance, so one run covers the four-word, six-word and eight-word recurrences, including the offset 192-bit boundary. The scoreboard takes its expected round keys from a separate word-by-word expansion model that finds S-box inverses by search. The final round keys of the standard example keys are also pinned to known constants. Hold windows are placed at round 0, in the middle of a run and at the last round, so that R8 is seen with the lanes both drawing on key words and on the recurrence.

// File: rtl/keysched_pkg.sv
package keysched_pkg;

    localparam int WORD_W   = 32;
    localparam int RK_WORDS = 4;
    localparam int WIN_W    = 8;
    localparam int KEY_W    = WORD_W * WIN_W;
    localparam int RK_W     = WORD_W * RK_WORDS;
    localparam int RND_W    = 4;
    localparam int NK_W     = 4;
    localparam int PH_W     = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RK_W-1:0]   rkey_t;

    typedef enum logic [1:0] {
        KS_HOLD = 2'd0,
        KS_K128 = 2'd1,
        KS_K192 = 2'd2,
        KS_K256 = 2'd3
    } ks_mode_e;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc, sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254, zero maps to zero
    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] acc, sq;
        acc = 8'h01;
        sq  = a;
        for (int k = 1; k < 8; k++) begin
            sq  = gmul(sq, sq);
            acc = gmul(acc, sq);
        end
        return acc;
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = ginv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    function automatic word_t sub_word(input word_t w);
        word_t r;
        for (int k = 0; k < WORD_W / 8; k++)
            r[k*8 +: 8] = sbox(w[k*8 +: 8]);
        return r;
    endfunction

    function automatic word_t rot_word(input word_t w);
        return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
    endfunction

    function automatic logic [NK_W-1:0] nk_of(input ks_mode_e m);
        case (m)
            KS_K192: return NK_W'(6);
            KS_K256: return NK_W'(8);
            default: return NK_W'(4);
        endcase
    endfunction

    function automatic logic [RND_W-1:0] last_of(input ks_mode_e m);
        return RND_W'(nk_of(m)) + RND_W'(6);
    endfunction

endpackage

// File: rtl/ks_lane.sv
module ks_lane
    import keysched_pkg::*;
(
    input  word_t            prev,
    input  word_t            back,
    input  word_t            keyw,
    input  logic             use_key,
    input  logic [PH_W-1:0]  phase,
    input  logic             wide,
    input  logic [7:0]       rcon,
    output word_t            nxt,
    output logic             rcon_use
);
    word_t sub_in, sub_out;

    always_comb begin
        sub_in  = (phase == '0) ? rot_word(prev) : prev;
        sub_out = sub_word(sub_in);
        rcon_use = 1'b0;
        if (use_key) begin
            nxt = keyw;
        end else if (phase == '0) begin
            nxt = back ^ sub_out ^ {rcon, {(WORD_W-8){1'b0}}};
            rcon_use = 1'b1;
        end else if (wide && phase == PH_W'(4)) begin
            nxt = back ^ sub_out;
        end else begin
            nxt = back ^ prev;
        end
    end
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
    import keysched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ks_mode_e         mode,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic [RND_W-1:0] rnd
);
    logic [RND_W-1:0] last_q;

    assign load = start && (mode != KS_HOLD);
    assign step = !load && (mode != KS_HOLD) && (rnd != last_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd    <= '0;
            last_q <= '0;
        end else if (load) begin
            rnd    <= '0;
            last_q <= last_of(mode);
        end else if (step) begin
            rnd    <= rnd + RND_W'(1);
        end
    end

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != KS_HOLD && !start && rnd < last_q) |=> rnd == $past(rnd) + RND_W'(1));

    // R7
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && rnd == last_q) |=> $stable(rnd));

    // R7
    rnd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd <= last_q);
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import keysched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 start,
    input  logic [KEY_W-1:0]     key_in,
    output logic [RK_W-1:0]      rkey,
    output logic [RND_W-1:0]     rnd
);
    ks_mode_e        mode_e;
    logic            load, step;
    word_t           win [WIN_W];
    logic [RK_W-1:0] key_hi;
    logic [PH_W-1:0] pos;
    logic [7:0]      rcon;
    logic [NK_W-1:0] nk;

    word_t                lane_out  [RK_WORDS];
    logic [RK_WORDS-1:0]  rcon_use;
    logic [NK_W-1:0]      back_off;
    logic [NK_W-1:0]      pos_sum;
    logic [PH_W-1:0]      pos_nxt;

    assign mode_e   = ks_mode_e'(mode);
    assign back_off = NK_W'(WIN_W) - nk;

    ks_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_e),
        .start (start),
        .load  (load),
        .step  (step),
        .rnd   (rnd)
    );

    for (genvar j = 0; j < RK_WORDS; j++) begin : g_lane
        word_t           prev_w, back_w;
        logic [NK_W-1:0] ph_sum, bidx;
        logic [PH_W-1:0] ph;
        logic            from_key;

        always_comb begin
            ph_sum = NK_W'(pos) + NK_W'(j);
            if (ph_sum >= nk) ph_sum = ph_sum - nk;
            ph       = ph_sum[PH_W-1:0];
            bidx     = back_off + NK_W'(j);
            back_w   = win[bidx[PH_W-1:0]];
            from_key = (rnd == '0) && ((NK_W'(RK_WORDS) + NK_W'(j)) < nk);
        end

        if (j == 0) begin : g_first
            assign prev_w = win[WIN_W-1];
        end else begin : g_chain
            assign prev_w = lane_out[j-1];
        end

        ks_lane u_lane (
            .prev     (prev_w),
            .back     (back_w),
            .keyw     (key_hi[RK_W-1-WORD_W*j -: WORD_W]),
            .use_key  (from_key),
            .phase    (ph),
            .wide     (nk == NK_W'(8)),
            .rcon     (rcon),
            .nxt      (lane_out[j]),
            .rcon_use (rcon_use[j])
        );
    end

    always_comb begin
        pos_sum = NK_W'(pos) + NK_W'(RK_WORDS);
        if (pos_sum >= nk) pos_sum = pos_sum - nk;
        pos_nxt = pos_sum[PH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rkey   <= '0;
            key_hi <= '0;
            pos    <= '0;
            rcon   <= 8'h01;
            nk     <= NK_W'(4);
            for (int k = 0; k < WIN_W; k++) win[k] <= '0;
        end else if (load) begin
            nk     <= nk_of(mode_e);
            pos    <= (mode_e == KS_K128) ? PH_W'(0) : PH_W'(RK_WORDS);
            rcon   <= 8'h01;
            key_hi <= key_in[RK_W-1:0];
            rkey   <= key_in[KEY_W-1 -: RK_W];
            for (int k = 0; k < RK_WORDS; k++) begin
                win[k]            <= '0;
                win[RK_WORDS + k] <= key_in[KEY_W-1-WORD_W*k -: WORD_W];
            end
        end else if (step) begin
            pos  <= pos_nxt;
            rcon <= (|rcon_use) ? xtime(rcon) : rcon;
            for (int k = 0; k < RK_WORDS; k++) begin
                win[k]            <= win[RK_WORDS + k];
                win[RK_WORDS + k] <= lane_out[k];
                rkey[RK_W-1-WORD_W*k -: WORD_W] <= lane_out[k];
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rnd == '0 && rkey == '0));

    // R2
    load_key0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode != 2'd0) |=> (rnd == '0 && rkey == $past(key_in[KEY_W-1 -: RK_W])));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> ($stable(rkey) && $stable(rnd) && $stable(rcon) && $stable(pos)));

    // R3
    rcon_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rcon_use) <= 1);

    // R5
    nk_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nk == NK_W'(4) || nk == NK_W'(6) || nk == NK_W'(8)));
endmodule

// File: tb/sim_aes_key_sched.sv
module sim_aes_key_sched;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         start = 1'b0;
    logic [255:0] key_in = '0;
    logic [127:0] rkey;
    logic [3:0]   rnd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    aes_key_sched u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .start(start),
        .key_in(key_in), .rkey(rkey), .rnd(rnd)
    );

    typedef struct {
        int           r;
        logic [127:0] k;
        string        tag;
    } item_t;
    item_t sbq[$];
    item_t last_item;

    logic [31:0] ew [0:59];

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        logic [7:0] s;
        for (int y = 1; y < 256; y++)
            if (m_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
        s = 8'h63;
        for (int r = 0; r < 5; r++) s = s ^ ((inv << r) | (inv >> (8 - r)));
        return s;
    endfunction

    function automatic logic [31:0] m_sub(input logic [31:0] w);
        return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
    endfunction

    task automatic expand(input logic [255:0] key, input int nk);
        logic [31:0] t;
        logic [7:0]  rc;
        for (int i = 0; i < nk; i++) ew[i] = key[255 - 32*i -: 32];
        for (int i = nk; i < 4 * (nk + 7); i++) begin
            t = ew[i-1];
            if (i % nk == 0) begin
                rc = 8'h01;
                for (int n = 1; n < i / nk; n++) rc = m_mul(rc, 8'h02);
                t = m_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            end else if (nk == 8 && i % nk == 4) begin
                t = m_sub(t);
            end
            ew[i] = ew[i-nk] ^ t;
        end
    endtask

    function automatic logic [127:0] rk_of(input int r);
        return {ew[4*r], ew[4*r+1], ew[4*r+2], ew[4*r+3]};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input int r, input string tag);
        item_t it;
        it.r = r;
        it.k = rk_of(r);
        it.tag = tag;
        sbq.push_back(it);
        last_item = it;
    endtask

    // monitor: one comparison per clock while expectations are queued
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                check({it.tag, " round index"}, 128'(rnd), 128'(it.r));
                check({it.tag, " round key"}, rkey, it.k);
            end
        end
    end

    task automatic run_key(input logic [255:0] key, input logic [1:0] m,
                           input int fr_at, input int fr_len, input string tag);
        int nk = (m == 2'd1) ? 4 : (m == 2'd2) ? 6 : 8;
        int nr = nk + 6;
        int total = nr + 1 + fr_len + 2;
        expand(key, nk);
        @(negedge clk);
        key_in = key;
        mode   = m;
        start  = 1'b1;
        for (int r = 0; r <= nr; r++) begin
            push(r, (r == 0) ? "R2" : ((r == 1) ? "R3" : tag));
            if (r == fr_at)
                for (int n = 0; n < fr_len; n++) push(r, "R8");
        end
        push(nr, "R7");
        push(nr, "R7");
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (fr_len > 0 && k == fr_at + 1) mode = 2'd0;
            if (fr_len > 0 && k == fr_at + 1 + fr_len) mode = m;
        end
    endtask

    // R9: a strobe under mode 0 leaves the last round key in place
    task automatic idle_start();
        logic [1:0] keep = mode;
        @(negedge clk);
        start  = 1'b1;
        mode   = 2'd0;
        key_in = ~key_in;
        last_item.tag = "R9";
        sbq.push_back(last_item);
        sbq.push_back(last_item);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        mode  = keep;
        @(negedge clk);
    endtask

    localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    localparam logic [255:0] K192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
    localparam logic [255:0] K256 =
        256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset index", 128'(rnd), 128'd0);
        check("R1 reset key", rkey, 128'd0);
        rst_n = 1'b1;

        run_key(K128, 2'd1, -1, 0, "R4");
        check("R4 model round 1", rk_of(1), 128'ha0fafe1788542cb123a339392a6c7605);
        check("R4 final key", rkey, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        run_key(K192, 2'd2, 5, 3, "R5");
        check("R5 final key", rkey, 128'he98ba06f448c773c8ecc720401002202);

        idle_start();

        run_key(K256, 2'd3, 0, 2, "R6");
        check("R6 model round 3", rk_of(3), 128'ha8b09c1a93d194cdbe49846eb75d5b9a);
        check("R6 final key", rkey, 128'hfe4890d1e6188d0b046df344706c631e);

        run_key({256{2'b10}} ^ K256, 2'd1, 10, 2, "R4");
        run_key(~K192, 2'd2, -1, 0, "R5");
        run_key({K128[255:128], K256[127:0]}, 2'd3, 7, 1, "R6");
        idle_start();

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d expected round keys never seen (expected 0)", sbq.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R3: watchdog expired, actual hung expected finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule